// File: doc/BRIEF.md
# Packed-Word Transfer FIFO Pair

This block holds the data words of a serial bus controller on their way out to the bus and back in from it. Software writes 32-bit words into a transmit queue and reads 32-bit words from a receive queue through a small strobe-based register port. The bus-side engine works one byte at a time. It pulls transmit bytes from the head word, taking the lowest byte first. It hands received bytes to a packer that fills the lowest free byte lane of a word, and a full or closed word is pushed into the receive queue.

A control register sets a fill-level trigger for each direction and holds self-clearing flush requests. A status register reports the free transmit slots, the filled receive slots and two sticky error flags. Two data-request outputs tell the host when the transmit queue has room or the receive queue holds data, each against its own programmable level.

Top module: `xfer_fifo_top`

## Requirements
- R1: After reset, the control register (select 0) reads 0xE0 (transmit trigger 7 in bits [7:5], receive trigger 0 in bits [4:2], flush bits [1:0] clear), the status register (select 1) reads 0x80, tx_req_o is 1 and rx_req_o is 0.
- R2: A register write at select 2 appends the word to the transmit queue. Status bits [7:4] give the free transmit slots (DEPTH minus filled), and words leave in the order they were written.
- R3: A write at select 2 while the transmit queue is full is dropped and leaves the queue unchanged. It sets status bit 8, which stays set until the next transmit flush.
- R4: A read at select 3 returns the oldest receive word and removes it. On an empty queue it returns 0 and sets status bit 9, which stays set until the next receive flush.
- R5: Writing 1 to control bit 1 (transmit) or bit 0 (receive) makes that bit read 1 for one cycle. The queue is then empty, its error flag is clear and the bit reads 0.
- R6: With trigger field T, tx_req_o is 1 exactly while free transmit slots are at least T+1, and rx_req_o is 1 exactly while filled receive slots are at least T+1. Both trigger fields are writable.
- R7: tx_byte_o shows byte lane 0 (bits [7:0]) of the head word first. Each accepted take (tx_take_i with tx_avail_o high) moves to the next lane, and the take of lane 3 retires the word.
- R8: A take with tx_end_i high retires the head word after that byte, so the next take returns lane 0 of the following word. tx_avail_o is low while the transmit queue is empty.
- R9: Received bytes fill lanes in order from bits [7:0] upward, and the fourth byte pushes the completed word into the receive queue.
- R10: A put with rx_end_i high pushes the partial word at once, with the unfilled upper lanes zero.
- R11: A transmit write and a word retire in the same cycle both take effect, as do a receive read and a receive push. A push during the flush-clear cycle is discarded.
- R12: rx_room_o is low while the receive queue is full, and a word completed then is dropped without changing the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops the receive queue at select 3) |
| reg_sel_i | input | 2 | Register select: 0 control, 1 status, 2 transmit data, 3 receive data |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on the select |
| tx_byte_o | output | 8 | Current transmit byte lane of the head word |
| tx_avail_o | output | 1 | Transmit queue holds a word |
| tx_take_i | input | 1 | Engine takes the current transmit byte |
| tx_end_i | input | 1 | Taken byte is the last of its word |
| rx_byte_i | input | 8 | Received byte from the engine |
| rx_put_i | input | 1 | Engine delivers rx_byte_i |
| rx_end_i | input | 1 | Delivered byte closes the word |
| rx_room_o | output | 1 | Receive queue can take a word |
| tx_req_o | output | 1 | Transmit data request |
| rx_req_o | output | 1 | Receive data request |

## Verification
Each queue has one port for the host and one for the engine, and the two can act in the same cycle. The bench drives both in one cycle: a transmit register write together with a byte take that closes the head word, and a receive register read together with a put that closes a new word. It judges the result from the byte or word seen during that cycle, which must be the old head, and from the status count afterwards, which must be unchanged. It also aims a put at the single cycle in which a flush is being carried out and expects the receive count to be zero afterwards.

// File: rtl/xfer_fifo_pkg.sv
package xfer_fifo_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES = 4;
  localparam int WORD_W = BYTE_W * LANES;
  localparam int TRIG_W = 3;
  localparam int LVL_W = 4;

  // control register layout
  localparam int CTL_RX_FLUSH = 0;
  localparam int CTL_TX_FLUSH = 1;
  localparam int CTL_RX_TRIG = 2;
  localparam int CTL_TX_TRIG = 5;
  // status register layout
  localparam int STA_RX_LVL = 0;
  localparam int STA_TX_LVL = 4;
  localparam int STA_TX_OVF = 8;
  localparam int STA_RX_UNF = 9;

  localparam logic [TRIG_W-1:0] TX_TRIG_RST = 3'd7;
  localparam logic [TRIG_W-1:0] RX_TRIG_RST = 3'd0;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_TXD  = 2'd2,
    SEL_RXD  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/xfer_word_fifo.sv
module xfer_word_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic [CW-1:0]    count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic do_push, do_pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign count_o = count_q;
  assign data_o  = mem_q[rd_ptr_q];
  assign do_push = push_i & ~full_o & ~clr_i;
  assign do_pop  = pop_i & ~empty_o & ~clr_i;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
      count_q <= count_q + CW'(do_push) - CW'(do_pop);
    end
  end

  assert_count_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  assert_full_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && full_o && !pop_i && !clr_i |=> $stable(count_q));
  assert_empty_pop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && empty_o && !push_i && !clr_i |=> empty_o);
  assert_clear_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty_o);
endmodule

// File: rtl/xfer_tx_unpack.sv
module xfer_tx_unpack
  import xfer_fifo_pkg::*;
#(
  localparam int LW = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              avail_i,
  input  logic              take_i,
  input  logic              end_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              retire_o
);
  logic [LW-1:0] lane_q;
  logic accept;

  assign byte_o   = word_i[lane_q*BYTE_W +: BYTE_W];
  assign accept   = take_i & avail_i & ~clr_i;
  assign retire_o = accept & (end_i | (lane_q == LW'(LANES - 1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lane_q <= '0;
    else if (clr_i)    lane_q <= '0;
    else if (retire_o) lane_q <= '0;
    else if (accept)   lane_q <= lane_q + 1'b1;
  end

  assert_lane_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_o |=> lane_q == '0);
  assert_idle_take_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && !avail_i && !clr_i |=> $stable(lane_q));
endmodule

// File: rtl/xfer_rx_pack.sv
module xfer_rx_pack
  import xfer_fifo_pkg::*;
#(
  localparam int LW = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              put_i,
  input  logic              end_i,
  output logic [WORD_W-1:0] word_o,
  output logic              commit_o
);
  logic [LW-1:0] lane_q;
  logic [WORD_W-1:0] hold_q;

  // lanes at and above lane_q are zero in hold_q
  assign word_o   = hold_q | (WORD_W'(byte_i) << (lane_q * BYTE_W));
  assign commit_o = put_i & ~clr_i & (end_i | (lane_q == LW'(LANES - 1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_q <= '0;
      hold_q <= '0;
    end else if (clr_i || commit_o) begin
      lane_q <= '0;
      hold_q <= '0;
    end else if (put_i) begin
      lane_q <= lane_q + 1'b1;
      hold_q <= word_o;
    end
  end

  assert_pack_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> (lane_q == '0) && (hold_q == '0));
  assert_low_lane_first_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_q == '0) |-> (hold_q == '0));
endmodule

// File: rtl/xfer_fifo_top.sv
module xfer_fifo_top
  import xfer_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic        reg_rd_i,
  input  logic [1:0]  reg_sel_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic [7:0]  tx_byte_o,
  output logic        tx_avail_o,
  input  logic        tx_take_i,
  input  logic        tx_end_i,
  input  logic [7:0]  rx_byte_i,
  input  logic        rx_put_i,
  input  logic        rx_end_i,
  output logic        rx_room_o,
  output logic        tx_req_o,
  output logic        rx_req_o
);
  reg_sel_e sel;
  logic wr_ctrl, wr_txd, rd_rxd;
  logic [TRIG_W-1:0] tx_trig_q, rx_trig_q;
  logic [1:0] flush_q;
  logic tx_clr, rx_clr;
  logic ovf_q, unf_q;

  logic [WORD_W-1:0] tx_head, rx_head, rx_word;
  logic [CW-1:0] tx_count, rx_count, tx_free;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic tx_retire, rx_commit;
  logic [CW:0] tx_lvl, rx_lvl;

  assign sel     = reg_sel_e'(reg_sel_i);
  assign wr_ctrl = reg_wr_i && (sel == SEL_CTRL);
  assign wr_txd  = reg_wr_i && (sel == SEL_TXD);
  assign rd_rxd  = reg_rd_i && (sel == SEL_RXD);
  assign tx_clr  = flush_q[CTL_TX_FLUSH];
  assign rx_clr  = flush_q[CTL_RX_FLUSH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_trig_q <= TX_TRIG_RST;
      rx_trig_q <= RX_TRIG_RST;
      flush_q   <= '0;
    end else begin
      // flush request lives for exactly the clear cycle
      flush_q <= wr_ctrl ? {reg_wdata_i[CTL_TX_FLUSH], reg_wdata_i[CTL_RX_FLUSH]} : 2'b00;
      if (wr_ctrl) begin
        tx_trig_q <= reg_wdata_i[CTL_TX_TRIG +: TRIG_W];
        rx_trig_q <= reg_wdata_i[CTL_RX_TRIG +: TRIG_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= tx_clr ? 1'b0 : (ovf_q | (wr_txd & tx_full));
      unf_q <= rx_clr ? 1'b0 : (unf_q | (rd_rxd & rx_empty));
    end
  end

  xfer_word_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (tx_clr),
    .push_i  (wr_txd),
    .data_i  (reg_wdata_i),
    .pop_i   (tx_retire),
    .data_o  (tx_head),
    .count_o (tx_count),
    .full_o  (tx_full),
    .empty_o (tx_empty)
  );

  xfer_tx_unpack u_tx_unpack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (tx_clr),
    .word_i   (tx_head),
    .avail_i  (~tx_empty),
    .take_i   (tx_take_i),
    .end_i    (tx_end_i),
    .byte_o   (tx_byte_o),
    .retire_o (tx_retire)
  );

  xfer_rx_pack u_rx_pack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (rx_clr),
    .byte_i   (rx_byte_i),
    .put_i    (rx_put_i),
    .end_i    (rx_end_i),
    .word_o   (rx_word),
    .commit_o (rx_commit)
  );

  xfer_word_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (rx_clr),
    .push_i  (rx_commit),
    .data_i  (rx_word),
    .pop_i   (rd_rxd),
    .data_o  (rx_head),
    .count_o (rx_count),
    .full_o  (rx_full),
    .empty_o (rx_empty)
  );

  assign tx_avail_o = ~tx_empty;
  assign rx_room_o  = ~rx_full;
  assign tx_free    = CW'(DEPTH) - tx_count;
  assign tx_lvl     = (CW+1)'(tx_trig_q) + (CW+1)'(1);
  assign rx_lvl     = (CW+1)'(rx_trig_q) + (CW+1)'(1);
  assign tx_req_o   = (CW+1)'(tx_free) >= tx_lvl;
  assign rx_req_o   = (CW+1)'(rx_count) >= rx_lvl;

  always_comb begin
    reg_rdata_o = '0;
    unique case (sel)
      SEL_CTRL: begin
        reg_rdata_o[CTL_TX_FLUSH] = flush_q[CTL_TX_FLUSH];
        reg_rdata_o[CTL_RX_FLUSH] = flush_q[CTL_RX_FLUSH];
        reg_rdata_o[CTL_TX_TRIG +: TRIG_W] = tx_trig_q;
        reg_rdata_o[CTL_RX_TRIG +: TRIG_W] = rx_trig_q;
      end
      SEL_STAT: begin
        reg_rdata_o[STA_RX_LVL +: LVL_W] = LVL_W'(rx_count);
        reg_rdata_o[STA_TX_LVL +: LVL_W] = LVL_W'(tx_free);
        reg_rdata_o[STA_TX_OVF] = ovf_q;
        reg_rdata_o[STA_RX_UNF] = unf_q;
      end
      SEL_RXD:  reg_rdata_o = rx_empty ? '0 : rx_head;
      default:  reg_rdata_o = '0;
    endcase
  end

  assert_tx_flush_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_clr) |-> !tx_avail_o && !ovf_q);
  assert_rx_flush_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_clr) |-> rx_room_o && !rx_req_o && !unf_q);
  assert_ovf_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q && !tx_clr |=> ovf_q);
  assert_unf_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unf_q) |-> $past(rx_empty));
  assert_rx_req_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_count == '0 |-> !rx_req_o);
  assert_room_full_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_room_o && rx_commit && !rd_rxd && !rx_clr |=> !rx_room_o);
endmodule

// File: tb/xfer_fifo_top_bench.sv
`timescale 1ns/1ps
module xfer_fifo_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [7:0] tx_byte, rx_byte = 0;
  logic tx_avail, tx_take = 0, tx_end = 0;
  logic rx_put = 0, rx_end = 0, rx_room, tx_req, rx_req;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xfer_fifo_top u_xfer_fifo_top (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .tx_byte_o(tx_byte), .tx_avail_o(tx_avail), .tx_take_i(tx_take), .tx_end_i(tx_end),
    .rx_byte_i(rx_byte), .rx_put_i(rx_put), .rx_end_i(rx_end), .rx_room_o(rx_room),
    .tx_req_o(tx_req), .rx_req_o(rx_req)
  );

  // {req[3:0], is_read, pad, sel[1:0], value[31:0]}
  localparam int NV = 7;
  localparam logic [39:0] VEC [NV] = '{
    {4'd1, 1'b1, 1'b0, 2'd0, 32'h0000_00E0},
    {4'd1, 1'b1, 1'b0, 2'd1, 32'h0000_0080},
    {4'd2, 1'b0, 1'b0, 2'd2, 32'h1122_3344},
    {4'd2, 1'b0, 1'b0, 2'd2, 32'hA5A5_0001},
    {4'd2, 1'b1, 1'b0, 2'd1, 32'h0000_0060},
    {4'd6, 1'b0, 1'b0, 2'd0, 32'h0000_00A4},
    {4'd6, 1'b1, 1'b0, 2'd0, 32'h0000_00A4}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    reg_wr = 1; reg_sel = s; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] d);
    reg_rd = 1; reg_sel = s;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 0;
  endtask

  task automatic take(input logic e, output logic [7:0] b);
    tx_take = 1; tx_end = e;
    #1 b = tx_byte;
    @(posedge clk); #1;
    tx_take = 0; tx_end = 0;
  endtask

  task automatic put(input logic [7:0] b, input logic e);
    rx_put = 1; rx_byte = b; rx_end = e;
    @(posedge clk); #1;
    rx_put = 0; rx_end = 0;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0] b;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;

    // R1 request flags after reset
    check("R1 tx_req", {31'b0, tx_req}, 32'd1);
    check("R1 rx_req", {31'b0, rx_req}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][35]) begin
        rd(VEC[i][33:32], d);
        check($sformatf("R%0d vec%0d", VEC[i][39:36], i), d, VEC[i][31:0]);
      end else begin
        wr(VEC[i][33:32], VEC[i][31:0]);
      end
    end

    // R6: tx trigger 5 -> level 6; free 6 -> request
    check("R6 tx_req at level", {31'b0, tx_req}, 32'd1);
    wr(2'd2, 32'hDEAD_BEEF);
    check("R6 tx_req below level", {31'b0, tx_req}, 32'd0);

    // R7: lane order of head word
    take(0, b); check("R7 lane0", {24'b0, b}, 32'h44);
    take(0, b); check("R7 lane1", {24'b0, b}, 32'h33);
    take(0, b); check("R7 lane2", {24'b0, b}, 32'h22);
    take(0, b); check("R7 lane3", {24'b0, b}, 32'h11);
    rd(2'd1, d); check("R7 retired after lane3", d, 32'h60);

    // R8: early end
    take(1, b); check("R8 end byte", {24'b0, b}, 32'h01);
    take(0, b); check("R8 next word lane0", {24'b0, b}, 32'hEF);
    take(1, b);
    check("R8 avail low when empty", {31'b0, tx_avail}, 32'd0);
    rd(2'd1, d); check("R8 empty status", d, 32'h80);

    // R3: overflow
    for (int i = 0; i < 8; i++) wr(2'd2, 32'h10 + i);
    rd(2'd1, d); check("R3 full status", d, 32'h00);
    wr(2'd2, 32'h0000_0BAD);
    rd(2'd1, d); check("R3 overflow flag", d, 32'h100);
    take(1, b); check("R3 head kept", {24'b0, b}, 32'h10);

    // R5: tx flush self-clears
    wr(2'd0, 32'hA6);
    rd(2'd0, d); check("R5 tx flush pending", d, 32'hA6);
    rd(2'd0, d); check("R5 tx flush cleared", d, 32'hA4);
    rd(2'd1, d); check("R5 tx emptied, flag cleared", d, 32'h80);

    // R11: tx write and retire in the same cycle
    wr(2'd2, 32'h0A0B_0C0D);
    rd(2'd1, d); check("R2 one word", d, 32'h70);
    reg_wr = 1; reg_sel = 2'd2; reg_wdata = 32'h1B2B_3B4B;
    tx_take = 1; tx_end = 1;
    #1 b = tx_byte;
    @(posedge clk); #1;
    reg_wr = 0; tx_take = 0; tx_end = 0;
    check("R11 old head byte", {24'b0, b}, 32'h0D);
    rd(2'd1, d); check("R11 tx count unchanged", d, 32'h70);
    take(1, b); check("R11 new word head", {24'b0, b}, 32'h4B);

    // R9: full word pack
    put(8'h10, 0); put(8'h20, 0); put(8'h30, 0); put(8'h40, 0);
    rd(2'd1, d); check("R9 one rx word", d, 32'h81);
    check("R6 rx_req below level", {31'b0, rx_req}, 32'd0);
    rd(2'd3, d); check("R9 packed word", d, 32'h4030_2010);

    // R10: partial word
    put(8'h55, 0); put(8'h66, 1);
    put(8'h01, 0); put(8'h02, 0); put(8'h03, 0); put(8'h04, 0);
    check("R6 rx_req at level", {31'b0, rx_req}, 32'd1);
    rd(2'd3, d); check("R10 partial word", d, 32'h0000_6655);
    rd(2'd3, d); check("R4 fifo order", d, 32'h0403_0201);

    // R4: underflow
    rd(2'd3, d); check("R4 empty read zero", d, 32'h0);
    rd(2'd1, d); check("R4 underflow flag", d, 32'h280);

    // R5: rx flush
    wr(2'd0, 32'hA5);
    rd(2'd0, d); check("R5 rx flush pending", d, 32'hA5);
    rd(2'd1, d); check("R5 rx flag cleared", d, 32'h80);

    // R12: rx full drops
    for (int i = 1; i <= 8; i++) put(8'(i), 1);
    check("R12 room low", {31'b0, rx_room}, 32'd0);
    put(8'hEE, 1);
    rd(2'd1, d); check("R12 count kept", d, 32'h88);
    rd(2'd3, d); check("R12 head kept", d, 32'h1);
    wr(2'd0, 32'hA5);
    @(posedge clk); #1;

    // R11: rx read and push in the same cycle
    put(8'h77, 1);
    reg_rd = 1; reg_sel = 2'd3;
    rx_put = 1; rx_byte = 8'h99; rx_end = 1;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 0; rx_put = 0; rx_end = 0;
    check("R11 read old rx head", d, 32'h77);
    rd(2'd1, d); check("R11 rx count unchanged", d, 32'h81);
    rd(2'd3, d); check("R11 new rx word", d, 32'h99);

    // R11: push during clear cycle discarded
    wr(2'd0, 32'hA5);
    put(8'h31, 1);
    rd(2'd1, d); check("R11 flush beats push", d, 32'h80);

    done = 1;
    summary();
  end
endmodule